// File: doc/BRIEF.md
# In-Order Completion Queue

This block keeps the program order of instructions in flight between dispatch and retirement. It is a six-slot circular queue. The dispatch stage offers up to two instructions per cycle. Each instruction carries an identifying tag, the index of the architectural register it writes, and the index of the rename buffer that holds its result. The queue accepts as many as it has room for, and the oldest instruction of the pair always goes in first.

Execution units report completion by tag on parallel finish ports. A report marks the matching queue entry as done. Only the two oldest entries are examined for retirement. When they are done, they leave the queue in program order, and the block presents one rename-to-architectural writeback command for each. A flush input empties the whole queue in one cycle, for example when a branch turns out to be mispredicted.

Top module: `completion_queue`

## Requirements
- R1: After reset the queue is empty: no retire command is presented, and a dispatch pair offered in the first cycle is fully accepted (`disp_accept` = 2'b11).
- R2: The queue holds at most six instructions. With six entries occupied, `disp_accept` is 2'b00 whatever `disp_valid` is.
- R3: A pair is accepted only when at least two entries are free. With exactly one free entry, only slot 0 of the pair is accepted (`disp_accept` = 2'b01).
- R4: Slot 1 (`disp_valid[1]`) is never accepted unless slot 0 is offered and accepted in the same cycle.
- R5: A finish report for an allocated tag marks that entry done. If the entry is the oldest, it appears on retire port 0 in the next cycle, with the tag, destination register and rename-buffer index it was dispatched with.
- R6: Retirement is strictly in program order. A finished entry that is not among the two oldest, or whose older neighbour has not finished, does not retire.
- R7: At most two entries retire per cycle. Retire port 1 is valid only when retire port 0 is valid in the same cycle, and it carries the second-oldest entry.
- R8: A finish report for a tag that is not currently allocated changes nothing, including for an entry that is allocated later with that tag.
- R9: Entries that retire in a cycle cannot be allocated in that same cycle. They become free for dispatch in the next cycle.
- R10: In a cycle with `flush` high, nothing is accepted or retired. From the next cycle on the queue is empty, and its head and tail restart at slot 0.
- R11: Program order is kept when the circular pointers wrap past the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear every entry this cycle |
| disp_valid | input | 2 | Dispatch offers: bit 0 is the older slot, bit 1 the younger |
| disp0_tag | input | TAG_W (4) | Tag of dispatch slot 0 |
| disp0_dst | input | REG_W (5) | Architectural destination of slot 0 |
| disp0_rb | input | RB_W (3) | Rename-buffer index of slot 0 |
| disp1_tag | input | TAG_W (4) | Tag of dispatch slot 1 |
| disp1_dst | input | REG_W (5) | Architectural destination of slot 1 |
| disp1_rb | input | RB_W (3) | Rename-buffer index of slot 1 |
| disp_accept | output | 2 | Per-slot acceptance this cycle |
| fin_valid | input | NFIN (2) | Finish report strobes, one per port |
| fin_tag | input | NFIN*TAG_W (8) | Finish tags, port f in bits f*TAG_W upward |
| ret_valid | output | 2 | Retire commands: bit 0 is the oldest entry, bit 1 the next oldest |
| ret0_tag | output | TAG_W (4) | Tag retiring on port 0 |
| ret0_dst | output | REG_W (5) | Architectural register written by port 0 |
| ret0_rb | output | RB_W (3) | Rename buffer copied by port 0 |
| ret1_tag | output | TAG_W (4) | Tag retiring on port 1 |
| ret1_dst | output | REG_W (5) | Architectural register written by port 1 |
| ret1_rb | output | RB_W (3) | Rename buffer copied by port 1 |

## Verification
The assertions assume that dispatch never raises `disp_valid[1]` without `disp_valid[0]` when it expects a pair. They also assume that no tag is held by two live entries at once, since a duplicate would let one finish report mark both. The stimulus gives every live instruction a distinct tag and reuses a tag only after its entry has retired or been flushed. Finish reports go out only in cycles after the matching dispatch has been accepted, except for the deliberately stale or unknown tags that check R8.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;

  parameter int unsigned CQ_DEPTH   = 6;
  parameter int unsigned CQ_TAG_W   = 4;
  parameter int unsigned CQ_REG_W   = 5;
  parameter int unsigned CQ_RB_W    = 3;
  parameter int unsigned CQ_FIN_PORTS = 2;

  // Advance a circular slot index by inc (inc < depth).
  function automatic int unsigned cq_wrap(int unsigned p, int unsigned inc,
                                          int unsigned depth);
    int unsigned s;
    s = p + inc;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/cq_alloc.sv
`timescale 1ns/1ps
module cq_alloc
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = CQ_DEPTH,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             flush,
  input  logic [1:0]       disp_valid,
  input  logic [CNT_W-1:0] occ_q,
  input  logic [PTR_W-1:0] tail_q,
  output logic [1:0]       accept,
  output logic [PTR_W-1:0] wr_ptr0,
  output logic [PTR_W-1:0] wr_ptr1
);

  logic [CNT_W-1:0] free_slots;

  // Vacancy comes from the registered occupancy only, so slots released by
  // retirement this cycle are not offered until the next one.
  always_comb begin
    free_slots = CNT_W'(DEPTH) - occ_q;
    accept[0]  = !flush && disp_valid[0] && (free_slots >= CNT_W'(1));
    accept[1]  = accept[0] && disp_valid[1] && (free_slots >= CNT_W'(2));
    wr_ptr0    = tail_q;
    wr_ptr1    = PTR_W'(cq_wrap(int'(tail_q), 1, DEPTH));
  end

endmodule

// File: rtl/cq_retire.sv
`timescale 1ns/1ps
module cq_retire
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = CQ_DEPTH,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             flush,
  input  logic [DEPTH-1:0] ent_vld,
  input  logic [DEPTH-1:0] ent_done,
  input  logic [PTR_W-1:0] head_q,
  output logic [1:0]       retire,
  output logic [PTR_W-1:0] rd_ptr0,
  output logic [PTR_W-1:0] rd_ptr1
);

  // Only the two bottom slots are looked at; the second is chained on the first.
  always_comb begin
    rd_ptr0   = head_q;
    rd_ptr1   = PTR_W'(cq_wrap(int'(head_q), 1, DEPTH));
    retire[0] = !flush && ent_vld[rd_ptr0] && ent_done[rd_ptr0];
    retire[1] = retire[0] && ent_vld[rd_ptr1] && ent_done[rd_ptr1];
  end

endmodule

// File: rtl/cq_ptrs.sv
`timescale 1ns/1ps
module cq_ptrs
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = CQ_DEPTH,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       accept,
  input  logic [1:0]       retire,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic [CNT_W-1:0] occ_q
);

  logic [PTR_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] occ_d;
  logic [CNT_W-1:0] n_acc, n_ret;
  logic             upd_en;

  always_comb begin
    n_acc  = CNT_W'(accept[0]) + CNT_W'(accept[1]);
    n_ret  = CNT_W'(retire[0]) + CNT_W'(retire[1]);
    upd_en = flush || (|accept) || (|retire);
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      occ_d  = '0;
    end else begin
      head_d = PTR_W'(cq_wrap(int'(head_q), int'(n_ret), DEPTH));
      tail_d = PTR_W'(cq_wrap(int'(tail_q), int'(n_acc), DEPTH));
      occ_d  = occ_q + n_acc - n_ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (upd_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

endmodule

// File: rtl/cq_slots.sv
`timescale 1ns/1ps
module cq_slots
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = CQ_DEPTH,
  parameter int unsigned TAG_W = CQ_TAG_W,
  parameter int unsigned REG_W = CQ_REG_W,
  parameter int unsigned RB_W  = CQ_RB_W,
  parameter int unsigned NFIN  = CQ_FIN_PORTS,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [1:0]                   wr_en,
  input  logic [PTR_W-1:0]             wr_ptr0,
  input  logic [PTR_W-1:0]             wr_ptr1,
  input  logic [TAG_W-1:0]             wr_tag0,
  input  logic [REG_W-1:0]             wr_dst0,
  input  logic [RB_W-1:0]              wr_rb0,
  input  logic [TAG_W-1:0]             wr_tag1,
  input  logic [REG_W-1:0]             wr_dst1,
  input  logic [RB_W-1:0]              wr_rb1,
  input  logic [1:0]                   clr_en,
  input  logic [PTR_W-1:0]             clr_ptr0,
  input  logic [PTR_W-1:0]             clr_ptr1,
  input  logic [NFIN-1:0]              fin_valid,
  input  logic [NFIN*TAG_W-1:0]        fin_tag,
  output logic [DEPTH-1:0]             ent_vld,
  output logic [DEPTH-1:0]             ent_done,
  output logic [DEPTH-1:0][TAG_W-1:0]  ent_tag,
  output logic [DEPTH-1:0][REG_W-1:0]  ent_dst,
  output logic [DEPTH-1:0][RB_W-1:0]   ent_rb
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             ld0, ld1, ld, clr, hit;
    logic             vld_d, done_d;
    logic [TAG_W-1:0] tag_d;
    logic [REG_W-1:0] dst_d;
    logic [RB_W-1:0]  rb_d;

    always_comb begin
      ld0 = wr_en[0] && (wr_ptr0 == PTR_W'(g));
      ld1 = wr_en[1] && (wr_ptr1 == PTR_W'(g));
      ld  = ld0 || ld1;
      clr = (clr_en[0] && (clr_ptr0 == PTR_W'(g))) ||
            (clr_en[1] && (clr_ptr1 == PTR_W'(g)));
      hit = 1'b0;
      for (int f = 0; f < int'(NFIN); f++) begin
        if (fin_valid[f] && (fin_tag[f*TAG_W +: TAG_W] == ent_tag[g])) hit = 1'b1;
      end
      if (flush) begin
        vld_d  = 1'b0;
        done_d = 1'b0;
      end else if (ld) begin
        vld_d  = 1'b1;
        done_d = 1'b0;
      end else if (clr) begin
        vld_d  = 1'b0;
        done_d = 1'b0;
      end else begin
        vld_d  = ent_vld[g];
        done_d = ent_done[g] || (ent_vld[g] && hit);
      end
      tag_d = ld1 ? wr_tag1 : wr_tag0;
      dst_d = ld1 ? wr_dst1 : wr_dst0;
      rb_d  = ld1 ? wr_rb1  : wr_rb0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g]  <= 1'b0;
        ent_done[g] <= 1'b0;
      end else begin
        ent_vld[g]  <= vld_d;
        ent_done[g] <= done_d;
      end
    end

    // Payload needs no reset: it is only read behind a valid bit.
    always_ff @(posedge clk) begin
      if (ld && !flush) begin
        ent_tag[g] <= tag_d;
        ent_dst[g] <= dst_d;
        ent_rb[g]  <= rb_d;
      end
    end
  end

endmodule

// File: rtl/completion_queue.sv
`timescale 1ns/1ps
module completion_queue
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = CQ_DEPTH,
  parameter int unsigned TAG_W = CQ_TAG_W,
  parameter int unsigned REG_W = CQ_REG_W,
  parameter int unsigned RB_W  = CQ_RB_W,
  parameter int unsigned NFIN  = CQ_FIN_PORTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [1:0]            disp_valid,
  input  logic [TAG_W-1:0]      disp0_tag,
  input  logic [REG_W-1:0]      disp0_dst,
  input  logic [RB_W-1:0]       disp0_rb,
  input  logic [TAG_W-1:0]      disp1_tag,
  input  logic [REG_W-1:0]      disp1_dst,
  input  logic [RB_W-1:0]       disp1_rb,
  output logic [1:0]            disp_accept,
  input  logic [NFIN-1:0]       fin_valid,
  input  logic [NFIN*TAG_W-1:0] fin_tag,
  output logic [1:0]            ret_valid,
  output logic [TAG_W-1:0]      ret0_tag,
  output logic [REG_W-1:0]      ret0_dst,
  output logic [RB_W-1:0]       ret0_rb,
  output logic [TAG_W-1:0]      ret1_tag,
  output logic [REG_W-1:0]      ret1_dst,
  output logic [RB_W-1:0]       ret1_rb
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]            head_q, tail_q;
  logic [CNT_W-1:0]            occ_q;
  logic [PTR_W-1:0]            wr_ptr0, wr_ptr1, rd_ptr0, rd_ptr1;
  logic [1:0]                  accept, retire;
  logic [DEPTH-1:0]            ent_vld, ent_done;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
  logic [DEPTH-1:0][REG_W-1:0] ent_dst;
  logic [DEPTH-1:0][RB_W-1:0]  ent_rb;

  cq_alloc #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_alloc (
    .flush      (flush),
    .disp_valid (disp_valid),
    .occ_q      (occ_q),
    .tail_q     (tail_q),
    .accept     (accept),
    .wr_ptr0    (wr_ptr0),
    .wr_ptr1    (wr_ptr1)
  );

  cq_retire #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_retire (
    .flush    (flush),
    .ent_vld  (ent_vld),
    .ent_done (ent_done),
    .head_q   (head_q),
    .retire   (retire),
    .rd_ptr0  (rd_ptr0),
    .rd_ptr1  (rd_ptr1)
  );

  cq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .accept (accept),
    .retire (retire),
    .head_q (head_q),
    .tail_q (tail_q),
    .occ_q  (occ_q)
  );

  cq_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .RB_W(RB_W),
             .NFIN(NFIN), .PTR_W(PTR_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (accept),
    .wr_ptr0   (wr_ptr0),
    .wr_ptr1   (wr_ptr1),
    .wr_tag0   (disp0_tag),
    .wr_dst0   (disp0_dst),
    .wr_rb0    (disp0_rb),
    .wr_tag1   (disp1_tag),
    .wr_dst1   (disp1_dst),
    .wr_rb1    (disp1_rb),
    .clr_en    (retire),
    .clr_ptr0  (rd_ptr0),
    .clr_ptr1  (rd_ptr1),
    .fin_valid (fin_valid),
    .fin_tag   (fin_tag),
    .ent_vld   (ent_vld),
    .ent_done  (ent_done),
    .ent_tag   (ent_tag),
    .ent_dst   (ent_dst),
    .ent_rb    (ent_rb)
  );

  always_comb begin
    disp_accept = accept;
    ret_valid   = retire;
    ret0_tag    = ent_tag[rd_ptr0];
    ret0_dst    = ent_dst[rd_ptr0];
    ret0_rb     = ent_rb[rd_ptr0];
    ret1_tag    = ent_tag[rd_ptr1];
    ret1_dst    = ent_dst[rd_ptr1];
    ret1_rb     = ent_rb[rd_ptr1];
  end

endmodule

// File: rtl/cq_checker.sv
`timescale 1ns/1ps
module cq_checker #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [1:0]       disp_accept,
  input logic [1:0]       ret_valid,
  input logic [CNT_W-1:0] occ
);

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= int'(DEPTH));

  a_r3_accept_room: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_accept) <= int'(DEPTH) - int'(occ));

  a_r4_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    disp_accept[1] |-> disp_accept[0]);

  a_r7_retire_chain: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[1] |-> ret_valid[0]);

  a_r9_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occ) == int'($past(occ)) + $countones($past(disp_accept))
                            - $countones($past(ret_valid)));

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (disp_accept == 2'b00) && (ret_valid == 2'b00));

  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

endmodule

bind completion_queue cq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .disp_accept (disp_accept),
  .ret_valid   (ret_valid),
  .occ         (occ_q)
);

// File: tb/tb_completion_queue.sv
`timescale 1ns/1ps
module tb_completion_queue;

  localparam int TAG_W = 4;
  localparam int REG_W = 5;
  localparam int RB_W  = 3;
  localparam int NFIN  = 2;

  logic                  clk, rst_n, flush;
  logic [1:0]            disp_valid, disp_accept, ret_valid;
  logic [TAG_W-1:0]      disp0_tag, disp1_tag, ret0_tag, ret1_tag;
  logic [REG_W-1:0]      disp0_dst, disp1_dst, ret0_dst, ret1_dst;
  logic [RB_W-1:0]       disp0_rb, disp1_rb, ret0_rb, ret1_rb;
  logic [NFIN-1:0]       fin_valid;
  logic [NFIN*TAG_W-1:0] fin_tag;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  completion_queue dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp0_tag(disp0_tag), .disp0_dst(disp0_dst), .disp0_rb(disp0_rb),
    .disp1_tag(disp1_tag), .disp1_dst(disp1_dst), .disp1_rb(disp1_rb),
    .disp_accept(disp_accept), .fin_valid(fin_valid), .fin_tag(fin_tag),
    .ret_valid(ret_valid), .ret0_tag(ret0_tag), .ret0_dst(ret0_dst),
    .ret0_rb(ret0_rb), .ret1_tag(ret1_tag), .ret1_dst(ret1_dst),
    .ret1_rb(ret1_rb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [REG_W-1:0] dst_of(logic [TAG_W-1:0] t);
    return REG_W'(t) + REG_W'(5);
  endfunction
  function automatic logic [RB_W-1:0] rb_of(logic [TAG_W-1:0] t);
    return t[RB_W-1:0] ^ RB_W'(3);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 1'b0; disp_valid = 2'b00; fin_valid = '0; fin_tag = '0;
    disp0_tag = '0; disp0_dst = '0; disp0_rb = '0;
    disp1_tag = '0; disp1_dst = '0; disp1_rb = '0;
  endtask

  // Next cycle: wait for the edge, then clear inputs shortly after it.
  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic settle(); #1; endtask

  task automatic offer(logic [1:0] v, logic [TAG_W-1:0] t0, logic [TAG_W-1:0] t1);
    disp_valid = v;
    disp0_tag = t0; disp0_dst = dst_of(t0); disp0_rb = rb_of(t0);
    disp1_tag = t1; disp1_dst = dst_of(t1); disp1_rb = rb_of(t1);
  endtask

  task automatic finish(logic [1:0] v, logic [TAG_W-1:0] t0, logic [TAG_W-1:0] t1);
    fin_valid = v;
    fin_tag   = {t1, t0};
  endtask

  task automatic chk_ret0(string req, logic [TAG_W-1:0] t);
    chk(req, "ret0_tag", 32'(ret0_tag), 32'(t));
    chk(req, "ret0_dst", 32'(ret0_dst), 32'(dst_of(t)));
    chk(req, "ret0_rb",  32'(ret0_rb),  32'(rb_of(t)));
  endtask

  task automatic chk_ret1(string req, logic [TAG_W-1:0] t);
    chk(req, "ret1_tag", 32'(ret1_tag), 32'(t));
    chk(req, "ret1_dst", 32'(ret1_dst), 32'(dst_of(t)));
    chk(req, "ret1_rb",  32'(ret1_rb),  32'(rb_of(t)));
  endtask

  // Reset state and filling all six slots with tags 1..6.
  task automatic t_reset_fill();
    tick();
    offer(2'b11, 4'd1, 4'd2); settle();
    chk("R1", "ret_valid after reset", 32'(ret_valid), 32'd0);
    chk("R1", "accept after reset", 32'(disp_accept), 32'h3);
    tick();
    offer(2'b11, 4'd3, 4'd4); settle();
    chk("R3", "accept with four free", 32'(disp_accept), 32'h3);
    tick();
    offer(2'b11, 4'd5, 4'd6); settle();
    chk("R2", "accept filling last two", 32'(disp_accept), 32'h3);
    tick();
    offer(2'b11, 4'd8, 4'd9); finish(2'b01, 4'd1, 4'd0); settle();
    chk("R2", "accept when full", 32'(disp_accept), 32'h0);
  endtask

  // Tag 1 retires; its slot is not usable until the next cycle.
  task automatic t_retire_gate();
    tick();
    offer(2'b11, 4'd8, 4'd9); settle();
    chk("R5", "ret_valid oldest finished", 32'(ret_valid), 32'h1);
    chk_ret0("R5", 4'd1);
    chk("R9", "accept while slot frees", 32'(disp_accept), 32'h0);
    tick();
    offer(2'b11, 4'd7, 4'd8); finish(2'b11, 4'd3, 4'd12); settle();
    chk("R3", "accept with one free", 32'(disp_accept), 32'h1);
    chk("R6", "ret_valid before finishes", 32'(ret_valid), 32'h0);
  endtask

  // Queue now holds 2..7; tag 3 done, unknown tag 12 reported.
  task automatic t_order();
    tick();
    finish(2'b01, 4'd2, 4'd0); settle();
    chk("R6", "younger done, oldest not", 32'(ret_valid), 32'h0);
    chk("R8", "unknown tag no retire", 32'(ret_valid), 32'h0);
    tick();
    settle();
    chk("R7", "two retire", 32'(ret_valid), 32'h3);
    chk_ret0("R7", 4'd2);
    chk_ret1("R7", 4'd3);
  endtask

  // Drain 4..7; tag 7 sits in slot 0 after the wrap.
  task automatic t_drain_wrap();
    tick();
    finish(2'b11, 4'd5, 4'd4); settle();
    chk("R7", "nothing ready", 32'(ret_valid), 32'h0);
    tick();
    finish(2'b11, 4'd7, 4'd6); settle();
    chk("R7", "pair 4,5", 32'(ret_valid), 32'h3);
    chk_ret0("R7", 4'd4);
    chk_ret1("R7", 4'd5);
    tick();
    settle();
    chk("R11", "pair across wrap", 32'(ret_valid), 32'h3);
    chk_ret0("R11", 4'd6);
    chk_ret1("R11", 4'd7);
    tick();
    offer(2'b01, 4'd10, 4'd0); settle();
    chk("R11", "empty after drain", 32'(ret_valid), 32'h0);
    chk("R4", "single offer", 32'(disp_accept), 32'h1);
  endtask

  // Flush with a ready entry, then stale finish after refill.
  task automatic t_flush();
    tick();
    offer(2'b10, 4'd11, 4'd11); settle();
    chk("R4", "slot1 alone refused", 32'(disp_accept), 32'h0);
    tick();
    finish(2'b01, 4'd10, 4'd0); settle();
    tick();
    flush = 1'b1; offer(2'b11, 4'd12, 4'd13); settle();
    chk("R10", "ret_valid during flush", 32'(ret_valid), 32'h0);
    chk("R10", "accept during flush", 32'(disp_accept), 32'h0);
    tick();
    offer(2'b11, 4'd10, 4'd13); settle();
    chk("R10", "ret_valid after flush", 32'(ret_valid), 32'h0);
    chk("R10", "accept after flush", 32'(disp_accept), 32'h3);
    tick();
    settle();
    chk("R8", "new tag10 not pre-done", 32'(ret_valid), 32'h0);
    tick();
    finish(2'b01, 4'd10, 4'd0); settle();
    tick();
    settle();
    chk("R10", "retire from slot 0", 32'(ret_valid), 32'h1);
    chk_ret0("R10", 4'd10);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset_fill();
    t_retire_gate();
    t_order();
    t_drain_wrap();
    t_flush();
    tick();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule